// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that software must restart at regular intervals with a two-write key sequence. An 8-bit counter advances on ticks taken from the oscillator clock. The clock first passes through a fixed base divider, then through a prescaler that a 3-bit code selects. If software does not restart the counter before it wraps past FFh, the block sends out a pulse on one of two lines. With the interrupt enable clear, the pulse goes on a reset request line. With it set, the pulse goes on an active-low interrupt line.

Software can also cause a reset request by mistake, in two ways: writing a key value that is not one of the two legal values, or writing the control register without the required check pattern. In both cases the reset request fires at once. Every reset request sets a sticky flag, and software clears it by writing 1. A disable bit can stop the counter, but only while a one-way override bit is still 1. Software can clear the override bit and can never set it again. The system reset controller that acts on the reset request line lies outside this block.

Registers are written through a simple write strobe with a 2-bit address, and read back through a separate combinational read port.

- Address 0 is the control register: bit 7 is the flag, bit 6 is the disable bit, bits 5..3 are the check bits and bits 2..0 are the prescale code.
- Address 1 is the key register. It reads as 0.
- Address 2 is the system register: bit 0 is the override bit, bit 1 is the interrupt enable and bit 2 is the read-only interrupt status.
- Address 3 reads the counter.

Top module: `keyed_wdog`

## Requirements
- R1: While reset is asserted the block reads as follows: the control register reads 00h, the system register reads 05h (override 1, interrupt enable 0, status 1), the counter reads 0, the reset request is 0 and the interrupt line is 1.
- R2: The counter advances by one every BASE_DIV × D clocks, counted from a restart. D is 1 for prescale codes 0 and 1, and 2^(code−1) for codes 2 to 7.
- R3: With interrupt enable 0, the tick that takes the counter from FFh to 00h raises the reset request on the next clock. The request stays high for PULSE_LEN clocks and the flag (control bit 7) becomes 1.
- R4: With interrupt enable 1, that overflow drives the interrupt line low for PULSE_LEN clocks instead. The reset request stays 0, system bit 2 reads 0 while the line is low, and the flag is not set.
- R5: Writing 55h to the key register arms a restart, and a later AAh write then clears the counter and the dividers. Repeated 55h writes keep the arm set. An AAh write with no arm leaves the counter running. An AAh write always drops the arm.
- R6: A key write of any value other than 55h or AAh raises the reset request on the next clock and sets the flag.
- R7: A control write whose bits 5..3 are not 101 raises the reset request on the next clock and sets the flag. The disable bit and the prescale code keep their old values.
- R8: Writing 1 to the flag position in a valid control write clears the flag. Writing 0 there leaves the flag unchanged.
- R9: While the disable bit and the override bit are both 1, the counter holds its value. Once the override bit is 0, the disable bit has no effect.
- R10: Writing 1 to system bit 0 clears the override bit. No write can set it back to 1.
- R11: Every reset request clears the counter and drops any armed restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; drives all counting |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 key, 2 system) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 key, 2 system, 3 counter) |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| wd_rst | output | 1 | Reset request pulse, active high |
| wd_int_n | output | 1 | Overflow interrupt pulse, active low |

## Verification
The bench builds the block with BASE_DIV = 4 and PULSE_LEN = 6, so a full 256-step count with the fastest prescale takes only 1024 clocks. This brings both overflow responses, and the exact width of the pulse they produce, within a short run. The small base divider also makes the slow prescale codes fast enough to measure: code 7 shows a count of 2 after 512 clocks. Every other check counts clock edges from a known restart, so the counter value that the bench reads back pins down the divider ratio exactly.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [2:0] CHECK_OK = 3'b101;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_KEY  = 2'd1,
    A_SYS  = 2'd2,
    A_CNT  = 2'd3
  } addr_e;

  // Mask of prescaler bits that must be all ones for a divided tick:
  // codes 0 and 1 give no division, code c >= 2 divides by 2^(c-1).
  function automatic logic [5:0] presc_mask(input logic [2:0] code);
    logic [6:0] one_hot;
    one_hot = 7'd1 << (code - 3'd1);
    presc_mask = (code <= 3'd1) ? 6'd0 : 6'(one_hot - 7'd1);
  endfunction
endpackage

// File: rtl/kwd_tick.sv
module kwd_tick #(
  parameter int BASE_DIV = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [5:0] mask,
  output logic       tick
);
  localparam int DIV_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BASE_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [5:0]       pre_q;
  logic             base_tick;

  assign base_tick = run && (div_q == DIV_LAST);
  assign tick      = base_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (clr) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (run) begin
      div_q <= base_tick ? '0 : div_q + 1'b1;
      if (base_tick) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwd_keychk.sv
module kwd_keychk
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       flush,
  output logic       restart,
  output logic       bad_key
);
  logic armed_q;

  assign restart = key_wr && (key_data == KEY_FIRE) && armed_q;
  assign bad_key = key_wr && (key_data != KEY_ARM) && (key_data != KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               armed_q <= 1'b0;
    else if (flush)                           armed_q <= 1'b0;
    else if (key_wr && key_data == KEY_ARM)   armed_q <= 1'b1;
    else if (key_wr && key_data == KEY_FIRE)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic fire_int,
  output logic rst_o,
  output logic int_n_o
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic [PC_W-1:0] left_q;
  logic            is_int_q;
  logic            active;

  assign active  = (left_q != '0);
  assign rst_o   = active && !is_int_q;
  assign int_n_o = !(active && is_int_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      is_int_q <= 1'b0;
    end else if (fire) begin
      left_q   <= PC_W'(PULSE_LEN);
      is_int_q <= fire_int;
    end else if (active) begin
      left_q   <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BASE_DIV  = 512,
  parameter int PULSE_LEN = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       wd_rst,
  output logic       wd_int_n
);
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       ps_q;
  logic             flag_q, dis_q, ovr_q, inten_q;

  logic ctrl_wr, key_wr, sys_wr;
  logic bad_chk, bad_key, restart;
  logic dis_eff, tick, ovf, rst_evt, fire;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign key_wr  = wr_en && (wr_addr == A_KEY);
  assign sys_wr  = wr_en && (wr_addr == A_SYS);
  assign bad_chk = ctrl_wr && (wr_data[5:3] != CHECK_OK);

  assign dis_eff = dis_q && ovr_q;
  assign ovf     = tick && (cnt_q == '1);
  assign rst_evt = (ovf && !inten_q) || bad_key || bad_chk;
  assign fire    = ovf || bad_key || bad_chk;

  kwd_tick #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!dis_eff), .clr(restart || rst_evt),
    .mask(presc_mask(ps_q)), .tick(tick)
  );

  kwd_keychk u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data),
    .flush(rst_evt), .restart(restart), .bad_key(bad_key)
  );

  kwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_int(!rst_evt),
    .rst_o(wd_rst), .int_n_o(wd_int_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (rst_evt || restart)  cnt_q <= '0;
    else if (tick)                cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      dis_q   <= 1'b0;
      ps_q    <= 3'd0;
      ovr_q   <= 1'b1;
      inten_q <= 1'b0;
    end else begin
      if (rst_evt)                      flag_q <= 1'b1;
      else if (ctrl_wr && wr_data[7])   flag_q <= 1'b0;
      if (ctrl_wr && !bad_chk) begin
        dis_q <= wr_data[6];
        ps_q  <= wr_data[2:0];
      end
      if (sys_wr && wr_data[0])         ovr_q   <= 1'b0;
      if (sys_wr)                       inten_q <= wr_data[1];
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = {flag_q, dis_q, 3'b000, ps_q};
      A_KEY:   rd_data = 8'h00;
      A_SYS:   rd_data = {5'b00000, wd_int_n, inten_q, ovr_q};
      default: rd_data = 8'(cnt_q);
    endcase
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_evt,
  input logic             restart,
  input logic             dis_eff,
  input logic             flag,
  input logic             ovr,
  input logic             wd_rst,
  input logic             wd_int_n,
  input logic [CNT_W-1:0] cnt
);
  // R3, R6, R7: every reset cause raises the request on the next clock
  p_evt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> wd_rst);

  // R3, R6, R7: every reset cause leaves the flag set
  p_evt_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> flag);

  // R11: a reset cause leaves the counter at zero
  p_evt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (cnt == '0));

  // R5: an accepted restart leaves the counter at zero
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R9: a frozen counter keeps its value
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_eff && !rst_evt && !restart) |=> $stable(cnt));

  // R10: once cleared, the override never returns to 1
  p_ovr_oneway_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr |=> !ovr);

  // R4: reset request and interrupt are never active together
  p_one_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rst && !wd_int_n));
endmodule

bind keyed_wdog kwd_checker #(.CNT_W(CNT_W)) u_kwd_checker (
  .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .restart(restart),
  .dis_eff(dis_eff), .flag(flag_q), .ovr(ovr_q), .wd_rst(wd_rst),
  .wd_int_n(wd_int_n), .cnt(cnt_q)
);

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
  localparam int BASE_DIV  = 4;
  localparam int PULSE_LEN = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       wd_rst, wd_int_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  keyed_wdog #(.CNT_W(8), .BASE_DIV(BASE_DIV), .PULSE_LEN(PULSE_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wd_rst(wd_rst), .wd_int_n(wd_int_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 sys", v, 8'h05);
    rd(2'd3, v); chk("R1 cnt", v, 0);
    chk("R1 wd_rst", wd_rst, 0);
    chk("R1 wd_int_n", wd_int_n, 1);
  endtask

  task automatic t_presc(input logic [2:0] code, input int n, input int exp);
    logic [7:0] v;
    wr(2'd0, 8'h28 | 8'(code));
    restart();
    edges(n);
    rd(2'd3, v); chk($sformatf("R2 code %0d", code), v, exp);
  endtask

  task automatic t_keyseq();
    logic [7:0] v;
    wr(2'd0, 8'h28);
    restart();
    edges(40);
    wr(2'd1, 8'hAA);
    rd(2'd3, v); chk("R5 lone AA ignored", v, 10);
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    rd(2'd3, v); chk("R5 55 AA clears", v, 0);
    edges(40);
    wr(2'd1, 8'hAA);
    rd(2'd3, v); chk("R5 arm dropped after AA", v, 10);
    wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
    rd(2'd3, v); chk("R5 repeated 55", v, 0);
  endtask

  task automatic t_badkey();
    logic [7:0] v;
    restart();
    edges(20);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'h23);
    chk("R6 bad key request", wd_rst, 1);
    rd(2'd0, v); chk("R6 flag", v[7], 1);
    rd(2'd3, v); chk("R11 cnt cleared", v, 0);
    edges(39);
    wr(2'd1, 8'hAA);
    rd(2'd3, v); chk("R11 arm dropped", v, 10);
    chk("R6 pulse ended", wd_rst, 0);
    wr(2'd0, 8'h28);
    rd(2'd0, v); chk("R8 write 0 keeps flag", v[7], 1);
    wr(2'd0, 8'hA8);
    rd(2'd0, v); chk("R8 write 1 clears flag", v[7], 0);
  endtask

  task automatic t_badchk();
    logic [7:0] v;
    wr(2'd0, 8'h2A);
    wr(2'd0, 8'h47);
    chk("R7 bad check request", wd_rst, 1);
    rd(2'd0, v); chk("R7 flag set, fields kept", v, 8'h82);
    edges(PULSE_LEN);
    wr(2'd0, 8'hA8);
  endtask

  task automatic t_ovf_rst();
    logic [7:0] v;
    restart();
    edges(1023);
    rd(2'd3, v); chk("R3 cnt before wrap", v, 255);
    chk("R3 no request yet", wd_rst, 0);
    edges(1);
    chk("R3 request", wd_rst, 1);
    chk("R3 no interrupt", wd_int_n, 1);
    edges(PULSE_LEN - 1);
    chk("R3 request held", wd_rst, 1);
    edges(1);
    chk("R3 request width", wd_rst, 0);
    rd(2'd0, v); chk("R3 flag", v[7], 1);
    wr(2'd0, 8'hA8);
  endtask

  task automatic t_ovf_int();
    logic [7:0] v;
    wr(2'd2, 8'h02);
    restart();
    edges(1024);
    chk("R4 interrupt", wd_int_n, 0);
    chk("R4 no request", wd_rst, 0);
    rd(2'd2, v); chk("R4 status", v, 8'h03);
    rd(2'd0, v); chk("R4 flag untouched", v[7], 0);
    edges(PULSE_LEN);
    chk("R4 interrupt width", wd_int_n, 1);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    wr(2'd0, 8'h68);
    restart();
    edges(100);
    rd(2'd3, v); chk("R9 frozen", v, 0);
    wr(2'd2, 8'h01);
    edges(40);
    rd(2'd3, v); chk("R9 disable ignored", v, 10);
    rd(2'd2, v); chk("R10 override cleared", v[0], 0);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R10 override stays 0", v[0], 0);
  endtask

  initial begin
    edges(2);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_presc(3'd0, 40, 10);
    t_presc(3'd1, 40, 10);
    t_presc(3'd2, 80, 10);
    t_presc(3'd3, 80, 5);
    t_presc(3'd7, 512, 2);
    t_keyseq();
    t_badkey();
    t_badchk();
    t_ovf_rst();
    t_ovf_int();
    t_disable();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule